// File: doc/BRIEF.md
# MSI Doorbell to Interrupt-Line Frame

This block is a small memory-mapped frame that converts message-signalled interrupt writes into pulses on a bank of interrupt output wires. An agent such as a PCI host bridge writes an absolute interrupt number to the frame's doorbell (trigger) register. The frame subtracts the absolute number of its first line to get a local line index. When that index falls inside the frame's window, the selected output wire pulses high for one clock. Any other payload is dropped silently.

The frame is set up at elaboration by two parameters. `BASE_IDX` is the first line's index counted in the shared-interrupt numbering, where index 0 is absolute interrupt 32. `LINE_COUNT` is the number of output wires, at most 128. Software finds the window by reading a type register. An identification register and a block of zero-reading peripheral ID slots complete the frame.

The bus is a plain 32-bit register port with write and read strobes and a size code. Read data is registered.

Top module: `msi_doorbell_frame`

## Requirements
- R1: While `rst` is high at a clock edge, every output line goes low and any queued pulse is cleared. `rd_data` also reads zero after that edge.
- R2: A word read of offset 0x008 returns `((BASE_IDX + 32) << 16) | LINE_COUNT`.
- R3: A word write to offset 0x040 takes bits [9:0] of `wr_data` as an absolute interrupt number N and ignores bits [31:10]. If N lies between BASE_IDX+32 and BASE_IDX+32+LINE_COUNT-1, it pulses output line N-(BASE_IDX+32).
- R4: A trigger payload below BASE_IDX+32 or above BASE_IDX+31+LINE_COUNT changes no output line and reports no error.
- R5: A pulse is registered. It is high during exactly the one cycle after the clock edge that accepted the write, and low in the cycle that follows.
- R6: Two trigger writes to the same line in consecutive cycles give two distinct one-cycle pulses, separated by one low cycle. Two writes to different lines in consecutive cycles each pulse their own line.
- R7: A word read of offset 0xFCC returns 0x0510043B: product code 0x51 in [27:20], revision 0 in [19:16] and implementer code 0x43B in [11:0].
- R8: Word reads of 0xFD4 through 0xFFC, and of every other offset not named in R2 or R7, return zero. Word writes to any offset other than 0x040 change no output.
- R9: `bus_size` encodes the access width as 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes. Only code 2 is honoured. Reads with any other code return zero, and writes with any other code are dropped.
- R10: `rd_data` is loaded on the clock edge where `rd_en` is high. It holds its value on every edge where `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 12 | Byte offset within the frame |
| wr_data | input | 32 | Write data |
| wr_en | input | 1 | Write strobe, one access per cycle it is high |
| rd_en | input | 1 | Read strobe |
| bus_size | input | 2 | Access width code (see R9) |
| rd_data | output | 32 | Registered read data |
| irq_o | output | LINE_COUNT | Interrupt output lines, one-cycle pulses |

## Verification
The bench drives payloads exactly at both window edges and one step outside each edge, plus 0 and 1023. A design with an off-by-one limit, or one that does the subtraction unsigned and wraps, would pulse a line on one of the outside values. It sets the upper data bits on a valid payload; a design that decodes all 32 bits would miss that write. Back-to-back writes to one line catch a design that merges them into a two-cycle level or loses the second write. Narrow-size accesses to the trigger and type offsets catch a design that decodes the offset but ignores the size code.

// File: rtl/msi_frame_pkg.sv
package msi_frame_pkg;

    localparam logic [11:0] OFF_TYPE   = 12'h008;
    localparam logic [11:0] OFF_TRIG   = 12'h040;
    localparam logic [11:0] OFF_IDENT  = 12'hFCC;
    localparam logic [11:0] OFF_PID_LO = 12'hFD0;
    localparam logic [11:0] OFF_PID_HI = 12'hFFC;

    localparam logic [1:0]  SZ_WORD    = 2'd2;
    localparam int          SHARED_OFS = 32;
    localparam int          MAX_LINES  = 128;

    localparam logic [7:0]  PRODUCT_CODE = 8'h51;
    localparam logic [3:0]  ARCH_REV     = 4'h0;
    localparam logic [11:0] IMPL_CODE    = 12'h43B;

    typedef enum logic [2:0] {
        RGN_NONE,
        RGN_TYPE,
        RGN_TRIG,
        RGN_IDENT,
        RGN_PID
    } region_e;

    typedef struct packed {
        logic    word;
        region_e rgn;
    } access_t;

    function automatic region_e classify(input logic [11:0] a);
        if (a == OFF_TYPE)                          return RGN_TYPE;
        else if (a == OFF_TRIG)                     return RGN_TRIG;
        else if (a == OFF_IDENT)                    return RGN_IDENT;
        else if (a > OFF_PID_LO && a <= OFF_PID_HI) return RGN_PID;
        else                                        return RGN_NONE;
    endfunction

    function automatic logic [31:0] ident_word();
        return {4'h0, PRODUCT_CODE, ARCH_REV, 4'h0, IMPL_CODE};
    endfunction

    function automatic logic [31:0] type_word(input int base_abs, input int count);
        return (32'(base_abs) << 16) | 32'(count);
    endfunction

endpackage

// File: rtl/msi_access_decode.sv
module msi_access_decode
    import msi_frame_pkg::*;
(
    input  logic [11:0] addr,
    input  logic [1:0]  bus_size,
    output access_t     acc
);
    always_comb begin
        acc.word = (bus_size == SZ_WORD);
        acc.rgn  = classify(addr);
    end
endmodule

// File: rtl/msi_window_map.sv
module msi_window_map #(
    parameter int BASE_ABS = 96,
    parameter int COUNT    = 32
) (
    input  logic             en,
    input  logic [9:0]       payload,
    output logic [COUNT-1:0] fire
);
    for (genvar i = 0; i < COUNT; i++) begin : g_line
        localparam logic [10:0] LINE_NUM = 11'(BASE_ABS + i);
        assign fire[i] = en && ({1'b0, payload} == LINE_NUM);
    end
endmodule

// File: rtl/msi_pulse_bank.sv
module msi_pulse_bank #(
    parameter int COUNT = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [COUNT-1:0] fire,
    output logic [COUNT-1:0] irq_q,
    output logic             pend_any
);
    logic [COUNT-1:0] pend_q;

    for (genvar i = 0; i < COUNT; i++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst) begin
                irq_q[i]  <= 1'b0;
                pend_q[i] <= 1'b0;
            end else if (irq_q[i]) begin
                irq_q[i]  <= 1'b0;
                pend_q[i] <= pend_q[i] | fire[i];
            end else begin
                irq_q[i]  <= pend_q[i] | fire[i];
                pend_q[i] <= pend_q[i] & fire[i];
            end
        end

        p_no_level_r5: assert property (@(posedge clk) disable iff (rst)
            irq_q[i] |=> !irq_q[i]);
        p_second_kept_r6: assert property (@(posedge clk) disable iff (rst)
            (irq_q[i] && fire[i]) |=> (!irq_q[i] ##1 irq_q[i]));
    end

    assign pend_any = |pend_q;
endmodule

// File: rtl/msi_doorbell_frame.sv
module msi_doorbell_frame
    import msi_frame_pkg::*;
#(
    parameter int BASE_IDX   = 64,
    parameter int LINE_COUNT = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [11:0]           addr,
    input  logic [31:0]           wr_data,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [1:0]            bus_size,
    output logic [31:0]           rd_data,
    output logic [LINE_COUNT-1:0] irq_o
);
    localparam int          BASE_ABS = BASE_IDX + SHARED_OFS;
    localparam logic [31:0] TYPE_VAL = type_word(BASE_ABS, LINE_COUNT);
    localparam logic [31:0] IDENT_VAL = ident_word();

    access_t     acc;
    logic        trig_en;
    logic        pend_any;
    logic [31:0] rd_next;
    logic [LINE_COUNT-1:0] fire;
    logic [21:0] unused_hi;

    assign unused_hi = wr_data[31:10];

    msi_access_decode u_dec (
        .addr     (addr),
        .bus_size (bus_size),
        .acc      (acc)
    );

    assign trig_en = wr_en && acc.word && (acc.rgn == RGN_TRIG);

    msi_window_map #(.BASE_ABS(BASE_ABS), .COUNT(LINE_COUNT)) u_map (
        .en      (trig_en),
        .payload (wr_data[9:0]),
        .fire    (fire)
    );

    msi_pulse_bank #(.COUNT(LINE_COUNT)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .fire     (fire),
        .irq_q    (irq_o),
        .pend_any (pend_any)
    );

    always_comb begin
        rd_next = '0;
        if (acc.word) begin
            unique case (acc.rgn)
                RGN_TYPE:  rd_next = TYPE_VAL;
                RGN_IDENT: rd_next = IDENT_VAL;
                default:   rd_next = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_data <= '0;
        else if (rd_en) rd_data <= rd_next;
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (irq_o == '0 && rd_data == '0));
    p_type_read_r2: assert property (@(posedge clk) disable iff (rst)
        (rd_en && bus_size == SZ_WORD && addr == OFF_TYPE) |=> rd_data == TYPE_VAL);
    p_window_miss_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == OFF_TRIG && irq_o == '0 && !pend_any &&
         (int'(wr_data[9:0]) < BASE_ABS || int'(wr_data[9:0]) >= BASE_ABS + LINE_COUNT))
        |=> irq_o == '0);
    p_ident_read_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_en && bus_size == SZ_WORD && addr == OFF_IDENT) |=> rd_data == 32'h0510_043B);
    p_narrow_read_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_en && bus_size != SZ_WORD) |=> rd_data == '0);
    p_narrow_write_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && bus_size != SZ_WORD && irq_o == '0 && !pend_any) |=> irq_o == '0);
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!rd_en && !$past(rst)) |=> $stable(rd_data));
endmodule

// File: tb/msi_doorbell_frame_test.sv
module msi_doorbell_frame_test;
    localparam int BASE = 64;
    localparam int CNT  = 32;
    localparam int LO   = BASE + 32;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [11:0]     addr = '0;
    logic [31:0]     wr_data = '0;
    logic            wr_en = 1'b0;
    logic            rd_en = 1'b0;
    logic [1:0]      bus_size = 2'd2;
    logic [31:0]     rd_data;
    logic [CNT-1:0]  irq_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    string cur_req = "R1";

    // behavioural reference state
    int          m_pend [CNT];
    logic [CNT-1:0] m_irq = '0;
    logic [31:0] m_rd = '0;
    bit          model_live = 1'b0;

    msi_doorbell_frame #(.BASE_IDX(BASE), .LINE_COUNT(CNT)) uut (
        .clk(clk), .rst(rst), .addr(addr), .wr_data(wr_data), .wr_en(wr_en),
        .rd_en(rd_en), .bus_size(bus_size), .rd_data(rd_data), .irq_o(irq_o)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        if (rst) begin
            m_irq = '0;
            m_rd  = '0;
            for (int i = 0; i < CNT; i++) m_pend[i] = 0;
        end else begin
            int p;
            int hit;
            p = int'(wr_data[9:0]);
            hit = -1;
            if (wr_en && bus_size == 2'd2 && addr == 12'h040 && p >= LO && p < LO + CNT)
                hit = p - LO;
            for (int i = 0; i < CNT; i++) begin
                int add;
                add = (i == hit) ? 1 : 0;
                if (m_irq[i]) begin
                    m_irq[i] = 1'b0;
                    m_pend[i] = m_pend[i] + add;
                end else if (m_pend[i] + add > 0) begin
                    m_irq[i] = 1'b1;
                    m_pend[i] = m_pend[i] + add - 1;
                end
            end
            if (rd_en) begin
                if (bus_size != 2'd2)      m_rd = '0;
                else if (addr == 12'h008)  m_rd = (32'(LO) << 16) | 32'(CNT);
                else if (addr == 12'hFCC)  m_rd = 32'h0510_043B;
                else                       m_rd = '0;
            end
        end
    end

    task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (model_live) begin
            check32({cur_req, " irq vs model"}, 32'(irq_o), 32'(m_irq));
            check32({cur_req, " rd_data vs model"}, rd_data, m_rd);
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
            finish_run();
        end
    end

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d, input logic [1:0] sz);
        @(negedge clk);
        addr = a; wr_data = d; bus_size = sz; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; bus_size = 2'd2;
    endtask

    task automatic bus_read(input logic [11:0] a, input logic [1:0] sz);
        @(negedge clk);
        addr = a; bus_size = sz; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0; bus_size = 2'd2;
    endtask

    function automatic logic [31:0] bit_of(input int line);
        return 32'(1) << line;
    endfunction

    task automatic miss_write(input string req, input logic [11:0] a, input logic [31:0] d,
                              input logic [1:0] sz);
        cur_req = req;
        bus_write(a, d, sz);
        check32({req, " no pulse"}, 32'(irq_o), 32'h0);
        @(negedge clk);
        check32({req, " still quiet"}, 32'(irq_o), 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_live = 1'b1;
        // R1: reset state
        check32("R1 irq after reset", 32'(irq_o), 32'h0);
        check32("R1 rd_data after reset", rd_data, 32'h0);

        // R2 type register
        cur_req = "R2";
        bus_read(12'h008, 2'd2);
        check32("R2 type value", rd_data, 32'h0060_0020);

        // R7 identification
        cur_req = "R7";
        bus_read(12'hFCC, 2'd2);
        check32("R7 ident value", rd_data, 32'h0510_043B);

        // R10 hold with no read
        cur_req = "R10";
        repeat (3) @(negedge clk);
        check32("R10 rd_data held", rd_data, 32'h0510_043B);

        // R8 zero regions
        cur_req = "R8";
        bus_read(12'hFD4, 2'd2);
        check32("R8 pid low", rd_data, 32'h0);
        bus_read(12'h008, 2'd2);
        bus_read(12'hFFC, 2'd2);
        check32("R8 pid high", rd_data, 32'h0);
        bus_read(12'h008, 2'd2);
        bus_read(12'h100, 2'd2);
        check32("R8 undefined offset", rd_data, 32'h0);
        bus_read(12'h008, 2'd2);
        bus_read(12'h009, 2'd2);
        check32("R8 unaligned offset", rd_data, 32'h0);

        // R9 narrow reads
        cur_req = "R9";
        bus_read(12'h008, 2'd2);
        bus_read(12'h008, 2'd1);
        check32("R9 half-word type read", rd_data, 32'h0);
        bus_read(12'hFCC, 2'd3);
        check32("R9 double-word ident read", rd_data, 32'h0);

        // R3/R5 lower edge of window
        cur_req = "R3";
        bus_write(12'h040, 32'(LO), 2'd2);
        check32("R3 lowest line pulses", 32'(irq_o), bit_of(0));
        @(negedge clk);
        check32("R5 pulse one cycle", 32'(irq_o), 32'h0);

        // R3 upper edge with high data bits set
        bus_write(12'h040, 32'hFFFF_FC00 | 32'(LO + CNT - 1), 2'd2);
        check32("R3 top line with high bits", 32'(irq_o), bit_of(CNT - 1));
        @(negedge clk);
        check32("R5 top pulse ends", 32'(irq_o), 32'h0);

        // R4 out of window
        miss_write("R4", 12'h040, 32'(LO - 1), 2'd2);
        miss_write("R4", 12'h040, 32'(LO + CNT), 2'd2);
        miss_write("R4", 12'h040, 32'h0, 2'd2);
        miss_write("R4", 12'h040, 32'h3FF, 2'd2);

        // R9 narrow writes, R8 wrong offsets
        miss_write("R9", 12'h040, 32'(LO + 3), 2'd0);
        miss_write("R9", 12'h040, 32'(LO + 3), 2'd3);
        miss_write("R8", 12'h044, 32'(LO + 3), 2'd2);
        miss_write("R8", 12'h008, 32'(LO + 3), 2'd2);
        cur_req = "R8";
        bus_read(12'h008, 2'd2);
        check32("R8 type unchanged by write", rd_data, 32'h0060_0020);

        // R6 back-to-back writes to one line
        cur_req = "R6";
        @(negedge clk);
        addr = 12'h040; wr_data = 32'(LO + 5); bus_size = 2'd2; wr_en = 1'b1;
        @(negedge clk);
        check32("R6 first pulse", 32'(irq_o), bit_of(5));
        @(negedge clk);
        wr_en = 1'b0;
        check32("R6 gap", 32'(irq_o), 32'h0);
        @(negedge clk);
        check32("R6 second pulse", 32'(irq_o), bit_of(5));
        @(negedge clk);
        check32("R6 after second", 32'(irq_o), 32'h0);

        // R6 different lines in consecutive cycles
        @(negedge clk);
        addr = 12'h040; wr_data = 32'(LO + 7); wr_en = 1'b1;
        @(negedge clk);
        wr_data = 32'(LO + 9);
        check32("R6 line 7 pulse", 32'(irq_o), bit_of(7));
        @(negedge clk);
        wr_en = 1'b0;
        check32("R6 line 9 pulse", 32'(irq_o), bit_of(9));
        @(negedge clk);
        check32("R6 both done", 32'(irq_o), 32'h0);

        // R1 reset in the middle of a queued pulse
        cur_req = "R1";
        @(negedge clk);
        addr = 12'h040; wr_data = 32'(LO + 2); wr_en = 1'b1;
        @(negedge clk);
        @(negedge clk);
        wr_en = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check32("R1 reset drops queued pulse", 32'(irq_o), 32'h0);
        @(negedge clk);
        check32("R1 no pulse after reset", 32'(irq_o), 32'h0);

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule